// File: doc/BRIEF.md
# Debug Bus Address/Data Match Unit

This block watches the CPU bus on behalf of an on-chip debugger and raises one match pulse per comparator whenever a bus access meets that comparator's programmed condition. It has three comparators, A, B and C. Each one holds a 24-bit match address, loaded one byte at a time. An access matches when its address equals the stored address. When the stored address is even, an access to the odd address just above it also matches, so an opcode fetched at an odd address is caught through the even address of its word. Each comparator can also require a given direction (read or write). Comparator B can in addition require a given access size, and comparator A can require that the data bus equal a reference value on the bits picked by a mask.

Comparators A and B can be joined into one inclusive address range. The range fires on accesses either inside it or outside it, and its result is reported on comparator A's output. Any comparator can instead be put in tagged mode. In tagged mode it ignores the bus and its qualifiers and reports only the execute-stage tag hit supplied by the opcode tracking logic. While the core is halted in background debug, or the debug port itself owns the bus, every output is held low. Configuration arrives through a byte-wide synchronous write port. The match outputs feed a state sequencer outside this block.

Top module: `dbg_match_unit`

## Requirements
- R1: A clock edge with `rstN` low clears every configuration register, so all comparators are disabled and the range is off, and drives `matchOut` to 0.
- R2: Comparator i (A=0, B=1, C=2) has its control byte at write address 4i, with bit0 as the enable bit. Its address bytes sit at 4i+1 (bits 23:16), 4i+2 (bits 15:8) and 4i+3 (bits 7:0). An enabled comparator with its tag clear drives `matchOut[i]` high in the cycle after a `busValid` access whose address equals the stored address. A disabled comparator never fires.
- R3: If the stored address is even (n-1), an access to n also matches. A stored odd address matches only itself, not the even address below it.
- R4: Control bit2 enables direction checking. Control bit3 then selects the direction required (1 = write, 0 = read), compared with `busWrite`.
- R5: On comparator B only, control bit4 enables size checking. Control bit5 then selects the size required (1 = word, 0 = byte), compared with `busWord`. On A and C these two bits have no effect.
- R6: Comparator A also requires `((busData ^ ref) & mask) == 0`. The 16-bit reference is written at addresses 12 (high byte) and 13 (low byte). The mask is written at 14 (high) and 15 (low), and a 1 in the mask makes that data bit take part in the compare. B and C ignore the data bus.
- R7: Write address 16 holds the range mode: bit0 turns the range on and bit1 selects outside mode. With the range on, `matchOut[0]` reports `lowA <= addr <= highB` (or its negation in outside mode), still subject to A's enable, direction and data checks. A's tag bit and the odd-address rule do not apply to the range. `matchOut[1]` stays 0 while the range is on.
- R8: Control bit1 sets tagged mode. A tagged comparator's output is its `tagHit` bit delayed by one cycle. Address, `busValid`, direction, size and data have no effect on it.
- R9: While `bgdActive` or `dbgPortAcc` is high in a cycle, all of `matchOut` is 0 in the next cycle, including tagged comparators.
- R10: No match is held or rechecked. Each access is judged on its own, so back-to-back matching accesses give back-to-back pulses and the output drops in the cycle after the first access that does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cfgWrEn | input | 1 | Configuration byte write strobe |
| cfgAddr | input | 5 | Configuration byte address |
| cfgWrData | input | 8 | Configuration byte value |
| busValid | input | 1 | A CPU bus access is present this cycle |
| busAddr | input | 24 | Access address |
| busWrite | input | 1 | 1 = write access, 0 = read |
| busWord | input | 1 | 1 = word access, 0 = byte |
| busData | input | 16 | Data bus value of the access |
| tagHit | input | 3 | Per-comparator tagged opcode reached execute |
| bgdActive | input | 1 | Core halted in background debug |
| dbgPortAcc | input | 1 | Debug port owns the bus this cycle |
| matchOut | output | 3 | Registered per-comparator match pulses |

## Verification
Every comparison result passes through exactly one output register, so a corrupted address byte, a mask bit or a control field shows up at `matchOut` in the cycle right after the first access it affects. The odd neighbour address, the two inclusive bounds of the range and accesses just outside them are the points where a wrong stored value or a wrong compare operator shows. A wrong write decode shows up as a comparator that fires on the wrong address, or that fires while it should be disabled, on the next probe. A suppression path that does not work shows up as a single stray pulse, one cycle after a halted or debug-port cycle.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;
  localparam int ADDR_BYTES = 3;
  localparam int DATA_BYTES = 2;
  localparam int NUM_CMP    = 3;
  localparam int ADDR_W     = 8 * ADDR_BYTES;
  localparam int DATA_W     = 8 * DATA_BYTES;
  localparam int CMP_STRIDE = 1 + ADDR_BYTES;
  localparam int DATA_BASE  = NUM_CMP * CMP_STRIDE;
  localparam int MASK_BASE  = DATA_BASE + DATA_BYTES;
  localparam int RANGE_OFS  = MASK_BASE + DATA_BYTES;
  localparam int CFG_AW     = $clog2(RANGE_OFS + 1);
  localparam int CMP_A = 0;
  localparam int CMP_B = 1;
  localparam int CMP_C = 2;

  // bit order matches the control byte: bit0 enable .. bit5 size select
  typedef struct packed {
    logic szSel;
    logic szEn;
    logic rwSel;
    logic rwEn;
    logic tag;
    logic enable;
  } cmpCfgT;

  typedef struct packed {
    logic [NUM_CMP-1:0][ADDR_BYTES-1:0] addrByteLd;
    logic [DATA_BYTES-1:0]              dataByteLd;
    logic [DATA_BYTES-1:0]              maskByteLd;
    logic [7:0]                         wrByte;
    cmpCfgT [NUM_CMP-1:0]               cmpCfg;
    logic                               rangeEn;
    logic                               rangeOutside;
    logic                               quiet;
  } ctrlBusT;
endpackage

// File: rtl/dbgm_ctrl.sv
module dbgm_ctrl
  import dbgm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [7:0]        cfgWrData,
  input  logic              bgdActive,
  input  logic              dbgPortAcc,
  output ctrlBusT           ctrlBus
);
  cmpCfgT [NUM_CMP-1:0]               cfgReg;
  logic   [NUM_CMP-1:0]               ctrlLd;
  logic   [NUM_CMP-1:0][ADDR_BYTES-1:0] addrLd;
  logic   [DATA_BYTES-1:0]            dataLd;
  logic   [DATA_BYTES-1:0]            maskLd;
  logic                               rangeLd;
  logic   [1:0]                       rangeReg;

  // write decode: control byte first, then address bytes high to low
  always_comb begin
    for (int i = 0; i < NUM_CMP; i++) begin
      ctrlLd[i] = cfgWrEn && (cfgAddr == CFG_AW'(i * CMP_STRIDE));
      for (int k = 0; k < ADDR_BYTES; k++)
        addrLd[i][k] = cfgWrEn && (cfgAddr == CFG_AW'(i * CMP_STRIDE + ADDR_BYTES - k));
    end
    for (int k = 0; k < DATA_BYTES; k++) begin
      dataLd[k] = cfgWrEn && (cfgAddr == CFG_AW'(DATA_BASE + DATA_BYTES - 1 - k));
      maskLd[k] = cfgWrEn && (cfgAddr == CFG_AW'(MASK_BASE + DATA_BYTES - 1 - k));
    end
    rangeLd = cfgWrEn && (cfgAddr == CFG_AW'(RANGE_OFS));
  end

  // size qualifier storage exists only for comparator B
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg   <= '0;
      rangeReg <= '0;
    end else begin
      for (int i = 0; i < NUM_CMP; i++) begin
        if (ctrlLd[i])
          cfgReg[i] <= (i == CMP_B) ? cmpCfgT'(cfgWrData[5:0])
                                    : cmpCfgT'({2'b00, cfgWrData[3:0]});
      end
      if (rangeLd) rangeReg <= cfgWrData[1:0];
    end
  end

  always_comb begin
    ctrlBus.addrByteLd   = addrLd;
    ctrlBus.dataByteLd   = dataLd;
    ctrlBus.maskByteLd   = maskLd;
    ctrlBus.wrByte       = cfgWrData;
    ctrlBus.cmpCfg       = cfgReg;
    ctrlBus.rangeEn      = rangeReg[0];
    ctrlBus.rangeOutside = rangeReg[1];
    ctrlBus.quiet        = bgdActive || dbgPortAcc;
  end
endmodule

// File: rtl/dbgm_datapath.sv
module dbgm_datapath
  import dbgm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlBusT            ctrlBus,
  input  logic               busValid,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrite,
  input  logic               busWord,
  input  logic [DATA_W-1:0]  busData,
  input  logic [NUM_CMP-1:0] tagHit,
  output logic [NUM_CMP-1:0] matchOut
);
  logic [NUM_CMP-1:0][ADDR_W-1:0] cmpAddr;
  logic [DATA_W-1:0]  dataRef;
  logic [DATA_W-1:0]  dataMask;
  logic [NUM_CMP-1:0] exactHit;
  logic [NUM_CMP-1:0] qualOk;
  logic [NUM_CMP-1:0] hitRaw;
  logic [NUM_CMP-1:0] enVec;
  logic               inRange;
  logic               rangeHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpAddr  <= '0;
      dataRef  <= '0;
      dataMask <= '0;
    end else begin
      for (int i = 0; i < NUM_CMP; i++)
        for (int k = 0; k < ADDR_BYTES; k++)
          if (ctrlBus.addrByteLd[i][k]) cmpAddr[i][8*k +: 8] <= ctrlBus.wrByte;
      for (int k = 0; k < DATA_BYTES; k++) begin
        if (ctrlBus.dataByteLd[k]) dataRef[8*k +: 8]  <= ctrlBus.wrByte;
        if (ctrlBus.maskByteLd[k]) dataMask[8*k +: 8] <= ctrlBus.wrByte;
      end
    end
  end

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    logic evenBase, rwOk, szOk, dataOk;
    assign evenBase    = !cmpAddr[i][0];
    assign exactHit[i] = (busAddr == cmpAddr[i]) ||
                         (evenBase && (busAddr == {cmpAddr[i][ADDR_W-1:1], 1'b1}));
    assign rwOk = !ctrlBus.cmpCfg[i].rwEn || (busWrite == ctrlBus.cmpCfg[i].rwSel);
    // size bits are held at zero by the control for all but comparator B
    assign szOk = !ctrlBus.cmpCfg[i].szEn || (busWord == ctrlBus.cmpCfg[i].szSel);
    if (i == CMP_A) begin : g_data
      assign dataOk = ((busData ^ dataRef) & dataMask) == '0;
    end else begin : g_nodata
      assign dataOk = 1'b1;
    end
    assign qualOk[i] = rwOk && szOk && dataOk;
    assign enVec[i]  = ctrlBus.cmpCfg[i].enable;
  end

  assign inRange  = (busAddr >= cmpAddr[CMP_A]) && (busAddr <= cmpAddr[CMP_B]);
  assign rangeHit = ctrlBus.rangeOutside ? !inRange : inRange;

  always_comb begin
    logic normalHit;
    for (int i = 0; i < NUM_CMP; i++) begin
      normalHit = ctrlBus.cmpCfg[i].tag ? tagHit[i]
                                        : (busValid && exactHit[i] && qualOk[i]);
      if (ctrlBus.rangeEn && i == CMP_A)
        hitRaw[i] = busValid && rangeHit && qualOk[i];
      else if (ctrlBus.rangeEn && i == CMP_B)
        hitRaw[i] = 1'b0;
      else
        hitRaw[i] = normalHit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) matchOut <= '0;
    else       matchOut <= hitRaw & enVec & {NUM_CMP{!ctrlBus.quiet}};
  end
endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
  import dbgm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [CFG_AW-1:0]  cfgAddr,
  input  logic [7:0]         cfgWrData,
  input  logic               busValid,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrite,
  input  logic               busWord,
  input  logic [DATA_W-1:0]  busData,
  input  logic [NUM_CMP-1:0] tagHit,
  input  logic               bgdActive,
  input  logic               dbgPortAcc,
  output logic [NUM_CMP-1:0] matchOut
);
  ctrlBusT ctrlBus;

  dbgm_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgAddr    (cfgAddr),
    .cfgWrData  (cfgWrData),
    .bgdActive  (bgdActive),
    .dbgPortAcc (dbgPortAcc),
    .ctrlBus    (ctrlBus)
  );

  dbgm_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlBus  (ctrlBus),
    .busValid (busValid),
    .busAddr  (busAddr),
    .busWrite (busWrite),
    .busWord  (busWord),
    .busData  (busData),
    .tagHit   (tagHit),
    .matchOut (matchOut)
  );
endmodule

// File: rtl/dbg_match_unit_chk.sv
module dbg_match_unit_chk
  import dbgm_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               busValid,
  input logic [NUM_CMP-1:0] tagHit,
  input logic               bgdActive,
  input logic               dbgPortAcc,
  input ctrlBusT            ctrlBus,
  input logic [NUM_CMP-1:0] matchOut
);
  logic [NUM_CMP-1:0] enVec;
  always_comb
    for (int i = 0; i < NUM_CMP; i++) enVec[i] = ctrlBus.cmpCfg[i].enable;

  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> matchOut == '0);

  p_disabled_silent_r2: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (matchOut & ~$past(enVec)) == '0);

  p_range_b_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrlBus.rangeEn |=> !matchOut[CMP_B]);

  p_tag_follow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBus.cmpCfg[CMP_C].tag && ctrlBus.cmpCfg[CMP_C].enable && !bgdActive && !dbgPortAcc)
      |=> matchOut[CMP_C] == $past(tagHit[CMP_C]));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busValid && tagHit == '0) |=> matchOut == '0);

  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (bgdActive || dbgPortAcc) |=> matchOut == '0);
endmodule

bind dbg_match_unit dbg_match_unit_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busValid   (busValid),
  .tagHit     (tagHit),
  .bgdActive  (bgdActive),
  .dbgPortAcc (dbgPortAcc),
  .ctrlBus    (ctrlBus),
  .matchOut   (matchOut)
);

// File: tb/dbg_match_unit_test.sv
`timescale 1ns/1ps
module dbg_match_unit_test;
  import dbgm_pkg::*;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               cfgWrEn = 1'b0;
  logic [CFG_AW-1:0]  cfgAddr = '0;
  logic [7:0]         cfgWrData = '0;
  logic               busValid = 1'b0;
  logic [ADDR_W-1:0]  busAddr = '0;
  logic               busWrite = 1'b0;
  logic               busWord = 1'b0;
  logic [DATA_W-1:0]  busData = '0;
  logic [NUM_CMP-1:0] tagHit = '0;
  logic               bgdActive = 1'b0;
  logic               dbgPortAcc = 1'b0;
  logic [NUM_CMP-1:0] matchOut;

  int vecCount = 0;
  int missCount = 0;
  logic [2:0] got;

  always #2 clk = ~clk;

  dbg_match_unit uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .busValid(busValid), .busAddr(busAddr),
    .busWrite(busWrite), .busWord(busWord), .busData(busData),
    .tagHit(tagHit), .bgdActive(bgdActive), .dbgPortAcc(dbgPortAcc),
    .matchOut(matchOut)
  );

  task automatic check(input string req, input string what, input logic [2:0] act, input logic [2:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic cfgWrite(input int a, input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = CFG_AW'(a); cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic setAddr(input int cmp, input logic [23:0] a);
    cfgWrite(cmp * 4 + 1, a[23:16]);
    cfgWrite(cmp * 4 + 2, a[15:8]);
    cfgWrite(cmp * 4 + 3, a[7:0]);
  endtask

  // one cycle of stimulus, result sampled one register later
  task automatic cycle(input logic v, input logic [23:0] a, input logic wr, input logic wd,
                       input logic [15:0] d, input logic [2:0] th, input logic bg,
                       input logic dp, output logic [2:0] res);
    @(negedge clk);
    busValid = v; busAddr = a; busWrite = wr; busWord = wd; busData = d;
    tagHit = th; bgdActive = bg; dbgPortAcc = dp;
    @(negedge clk);
    res = matchOut;
    busValid = 1'b0; tagHit = '0; bgdActive = 1'b0; dbgPortAcc = 1'b0;
  endtask

  task automatic rd(input logic [23:0] a, output logic [2:0] res);
    cycle(1'b1, a, 1'b0, 1'b0, 16'h0000, 3'b000, 1'b0, 1'b0, res);
  endtask

  task automatic testReset();
    check("R1", "output after reset", matchOut, 3'b000);
    rd(24'h000000, got);
    check("R1", "all disabled after reset", got, 3'b000);
  endtask

  task automatic testExact();
    setAddr(0, 24'h123456);
    setAddr(1, 24'h123456);
    cfgWrite(0, 8'h01);
    rd(24'h123456, got);
    check("R2", "A exact, B disabled", got, 3'b001);
    rd(24'h123458, got);
    check("R2", "A other address", got, 3'b000);
    rd(24'h123457, got);
    check("R3", "odd neighbour of even base", got, 3'b001);
    setAddr(2, 24'h000101);
    cfgWrite(8, 8'h01);
    rd(24'h000101, got);
    check("R3", "C odd base itself", got, 3'b100);
    rd(24'h000100, got);
    check("R3", "C odd base, even below", got, 3'b000);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    busValid = 1'b1; busAddr = 24'h123456; busWrite = 1'b0; busWord = 1'b0; busData = '0;
    @(negedge clk);
    check("R10", "first of pair", matchOut, 3'b001);
    busAddr = 24'h123457;
    @(negedge clk);
    check("R10", "second of pair", matchOut, 3'b001);
    busAddr = 24'h200000;
    @(negedge clk);
    check("R10", "drop after miss", matchOut, 3'b000);
    busValid = 1'b0;
  endtask

  task automatic testDirection();
    cfgWrite(0, 8'h0D);
    cycle(1'b1, 24'h123456, 1'b0, 1'b0, 16'h0, 3'b000, 1'b0, 1'b0, got);
    check("R4", "write required, read seen", got, 3'b000);
    cycle(1'b1, 24'h123456, 1'b1, 1'b0, 16'h0, 3'b000, 1'b0, 1'b0, got);
    check("R4", "write required, write seen", got, 3'b001);
  endtask

  task automatic testSize();
    setAddr(1, 24'h002000);
    cfgWrite(4, 8'h31);
    cycle(1'b1, 24'h002000, 1'b0, 1'b1, 16'h0, 3'b000, 1'b0, 1'b0, got);
    check("R5", "B word required, word seen", got, 3'b010);
    cycle(1'b1, 24'h002000, 1'b0, 1'b0, 16'h0, 3'b000, 1'b0, 1'b0, got);
    check("R5", "B word required, byte seen", got, 3'b000);
    cfgWrite(0, 8'h31);
    cycle(1'b1, 24'h123456, 1'b0, 1'b0, 16'h0, 3'b000, 1'b0, 1'b0, got);
    check("R5", "size bits ignored on A", got, 3'b001);
  endtask

  task automatic testData();
    cfgWrite(0, 8'h01);
    cfgWrite(12, 8'h5A); cfgWrite(13, 8'h3C);
    cfgWrite(14, 8'hFF); cfgWrite(15, 8'h00);
    cycle(1'b1, 24'h123456, 1'b0, 1'b0, 16'h5AFF, 3'b000, 1'b0, 1'b0, got);
    check("R6", "masked data equal", got, 3'b001);
    cycle(1'b1, 24'h123456, 1'b0, 1'b0, 16'h5BFF, 3'b000, 1'b0, 1'b0, got);
    check("R6", "masked data differs", got, 3'b000);
    cycle(1'b1, 24'h000101, 1'b0, 1'b0, 16'h1234, 3'b000, 1'b0, 1'b0, got);
    check("R6", "C ignores data", got, 3'b100);
    cfgWrite(14, 8'h00);
  endtask

  task automatic testRange();
    setAddr(0, 24'h001000);
    setAddr(1, 24'h001FFF);
    cfgWrite(4, 8'h01);
    cfgWrite(16, 8'h01);
    rd(24'h001000, got);  check("R7", "inside, low bound", got, 3'b001);
    rd(24'h001FFF, got);  check("R7", "inside, high bound, B silent", got, 3'b001);
    rd(24'h002000, got);  check("R7", "above range", got, 3'b000);
    rd(24'h000FFF, got);  check("R7", "below range", got, 3'b000);
    cfgWrite(16, 8'h03);
    rd(24'h002000, got);  check("R7", "outside mode, above", got, 3'b001);
    rd(24'h001800, got);  check("R7", "outside mode, inside", got, 3'b000);
    cfgWrite(16, 8'h00);
    rd(24'h001FFF, got);  check("R7", "range off, B exact again", got, 3'b010);
  endtask

  task automatic testTag();
    cfgWrite(8, 8'h07);
    cycle(1'b1, 24'h000101, 1'b1, 1'b0, 16'h0, 3'b000, 1'b0, 1'b0, got);
    check("R8", "tagged C ignores address", got, 3'b000);
    cycle(1'b0, 24'h000000, 1'b1, 1'b0, 16'h0, 3'b100, 1'b0, 1'b0, got);
    check("R8", "tagged C follows tag hit", got, 3'b100);
    cycle(1'b0, 24'h000000, 1'b0, 1'b0, 16'h0, 3'b001, 1'b0, 1'b0, got);
    check("R8", "untagged A ignores tag hit", got, 3'b000);
  endtask

  task automatic testQuiet();
    cycle(1'b0, 24'h000000, 1'b0, 1'b0, 16'h0, 3'b100, 1'b1, 1'b0, got);
    check("R9", "background debug blocks tag", got, 3'b000);
    cycle(1'b1, 24'h001000, 1'b0, 1'b0, 16'h0, 3'b000, 1'b0, 1'b1, got);
    check("R9", "debug port access blocks A", got, 3'b000);
    rd(24'h001000, got);
    check("R9", "A fires once unblocked", got, 3'b001);
  endtask

  initial begin
    #(4 * 200000);
    missCount++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testExact();
    testBackToBack();
    testDirection();
    testSize();
    testData();
    testRange();
    testTag();
    testQuiet();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule